// File: doc/BRIEF.md
# Broadcast-Merging Banked Memory Crossbar

This block connects a set of core request ports to a set of independently addressed memory banks. Every port can reach every bank. The path from a request to its bank is purely combinational, so an access that is granted completes in the cycle in which it is presented. The same block can sit in front of an instruction store or a data store. Only the word width and the port and bank counts change between the two uses.

Reads from several ports to the same word in the same cycle are merged into one bank access. The word that comes back is delivered to every one of those ports. Requests to different words of one bank compete. A write always wins over reads. Otherwise a per-bank rotating priority picks one address, and every port that is not served sees its stall line high for that cycle and must hold its request. Each bank has an enable line that is raised only when the bank is actually accessed, so idle banks stay quiet.

Top module: `bcast_xbar`

## Requirements
- R1: After reset, each bank's rotating priority starts at port 0, so the lowest-numbered requesting port wins the first conflict in any bank.
- R2: A port's word address selects bank `addr[BANK_W-1:0]` and row `addr[ADDR_W-1:BANK_W]`. A bank that is enabled is driven with the row of the served request, and the read word reaches the served port in the same cycle.
- R3: All reads to the same bank and row in one cycle are served together by a single bank access. None of those ports stalls, and each receives the same word.
- R4: When reads to different rows of one bank collide, only the ports reading the winner's row are served. Every other requesting port of that bank has its stall line high for that cycle.
- R5: After a bank serves a request, its priority starts at the port just after the winning port. A port that keeps losing is therefore served within N_PORTS cycles.
- R6: If any write targets a bank, one write is served in that cycle and every read to that bank stalls, even a read to the same row. The written word is visible to reads from the next cycle on.
- R7: Writes are never merged. Exactly one port's write reaches a bank in a cycle, and the other writers stall.
- R8: Requests to distinct banks do not interfere, and all of them are served in the same cycle.
- R9: A bank's enable is low in any cycle with no request to it, and its write strobe is high only when a write is served. A port that is not served, or that issues a write, returns zero read data.
- R10: Each bank reports a grant vector with bit i set when port i was served by that bank. A requesting port's stall line is high exactly when no bank granted it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | N_PORTS | Request present, one bit per port |
| req_write | input | N_PORTS | 1 = write, 0 = read, per port |
| req_addr | input | N_PORTS*ADDR_W | Word address per port |
| req_wdata | input | N_PORTS*DATA_W | Write data per port |
| req_stall | output | N_PORTS | Request not served this cycle |
| req_rdata | output | N_PORTS*DATA_W | Read data for served reads, else zero |
| bank_en | output | N_BANKS | Bank accessed this cycle |
| bank_we | output | N_BANKS | Bank access is a write |
| bank_addr | output | N_BANKS*ROW_W | Row within each bank |
| bank_wdata | output | N_BANKS*DATA_W | Write data to each bank |
| bank_rdata | input | N_BANKS*DATA_W | Combinational read data from each bank |
| bank_grant | output | N_BANKS*N_PORTS | Ports served by each bank |

## Verification
The bench aims at the cases where merging and arbitration interact. It sends four reads of one word, where a design that failed to merge would stall three ports. It puts a write among same-word reads, where a design that merged the write would let a read through or return stale data. It sends two writes to one word, where a wrongly merged pair would corrupt the store. It repeats a two-port conflict over consecutive cycles starting from reset. A priority pointer that failed to rotate, or that started at the wrong port, would serve the wrong port or starve one. Spreading reads over all banks exposes a bank decode that lets banks block each other.

// File: rtl/xbar_pkg.sv
`timescale 1ns/1ps
// Shared helpers for the crossbar.
// Assumes: counts are at least 1, widths are at least 1.
package xbar_pkg;
    // Width of an index able to name `count` items (minimum 1 bit).
    function automatic int idx_w(input int count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction
endpackage

// File: rtl/xbar_rr_pick.sv
`timescale 1ns/1ps
// Rotating-priority picker: returns the first set request bit found by
// scanning upward from `start`, wrapping at N.
// Assumes: start < N.
module xbar_rr_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     req,
    input  logic [IDX_W-1:0] start,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Scan from the start position and keep the first hit.
    always_comb begin
        int c;
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            c = int'(start) + i;
            if (c >= N) c = c - N;
            if (!found && req[c]) begin
                found = 1'b1;
                idx   = IDX_W'(c);
            end
        end
    end
endmodule

// File: rtl/xbar_bank_port.sv
`timescale 1ns/1ps
// One bank's arbiter and merger. Picks a write first, otherwise a read
// by rotating priority, merges all reads to the winner's row, drives the
// bank and keeps the rotating pointer.
// Assumes: `hit` already includes request valid and bank decode.
module xbar_bank_port #(
    parameter int N      = 4,
    parameter int ROW_W  = 8,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        hit,
    input  logic [N-1:0]        wr,
    input  logic [N*ROW_W-1:0]  row,
    input  logic [N*DATA_W-1:0] wdata,
    output logic                en,
    output logic                we,
    output logic [ROW_W-1:0]    addr,
    output logic [DATA_W-1:0]   wdata_o,
    output logic [N-1:0]        grant
);
    logic [IDX_W-1:0] ptr, w_idx, r_idx, win;
    logic             w_any, r_any;
    logic [N-1:0]     wr_req, rd_req;
    logic [ROW_W-1:0] win_row;

    assign wr_req = hit & wr;
    assign rd_req = hit & ~wr;

    xbar_rr_pick #(.N(N), .IDX_W(IDX_W)) u_wpick (
        .req(wr_req), .start(ptr), .found(w_any), .idx(w_idx));
    xbar_rr_pick #(.N(N), .IDX_W(IDX_W)) u_rpick (
        .req(rd_req), .start(ptr), .found(r_any), .idx(r_idx));

    assign win     = w_any ? w_idx : r_idx;
    assign win_row = row[win*ROW_W +: ROW_W];

    // Drive the bank: writes go alone, reads merge on the winner's row.
    always_comb begin
        en      = w_any | r_any;
        we      = w_any;
        addr    = en ? win_row : '0;
        wdata_o = w_any ? wdata[win*DATA_W +: DATA_W] : '0;
        grant   = '0;
        if (w_any) begin
            grant[win] = 1'b1;
        end else begin
            for (int i = 0; i < N; i++)
                grant[i] = rd_req[i] && (row[i*ROW_W +: ROW_W] == win_row);
        end
    end

    // Rotate priority to the port after the one just served.
    always_ff @(posedge clk) begin
        if (!rst_n)   ptr <= '0;
        else if (en)  ptr <= (int'(win) == N-1) ? '0 : win + 1'b1;
    end

    AST_GRANT_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~hit) == '0);                                  // R10
    AST_BANK_SERVES: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (grant != '0));                                  // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (hit == '0) |-> (!en && !we));                          // R9
    AST_WRITE_SOLO: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> $onehot(grant));                                 // R7
    AST_WRITE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit & wr) != '0) |-> ((grant & ~wr) == '0));          // R6
    AST_NO_IDLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |-> en);                                    // R4
endmodule

// File: rtl/bcast_xbar.sv
`timescale 1ns/1ps
// Fully connected single-cycle crossbar from N_PORTS request ports to
// N_BANKS memory banks with same-word read merging and broadcast.
// Assumes: bank read data is combinational on bank_addr; N_BANKS >= 2.
module bcast_xbar #(
    parameter int N_PORTS = 4,
    parameter int N_BANKS = 4,
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 16,
    localparam int BANK_W = xbar_pkg::idx_w(N_BANKS),
    localparam int ROW_W  = ADDR_W - BANK_W,
    localparam int IDX_W  = xbar_pkg::idx_w(N_PORTS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_PORTS-1:0]          req_valid,
    input  logic [N_PORTS-1:0]          req_write,
    input  logic [N_PORTS*ADDR_W-1:0]   req_addr,
    input  logic [N_PORTS*DATA_W-1:0]   req_wdata,
    output logic [N_PORTS-1:0]          req_stall,
    output logic [N_PORTS*DATA_W-1:0]   req_rdata,
    output logic [N_BANKS-1:0]          bank_en,
    output logic [N_BANKS-1:0]          bank_we,
    output logic [N_BANKS*ROW_W-1:0]    bank_addr,
    output logic [N_BANKS*DATA_W-1:0]   bank_wdata,
    input  logic [N_BANKS*DATA_W-1:0]   bank_rdata,
    output logic [N_BANKS*N_PORTS-1:0]  bank_grant
);
    logic [N_PORTS*ROW_W-1:0] rows;
    logic [N_PORTS-1:0]       hit   [N_BANKS];
    logic [N_PORTS-1:0]       grant [N_BANKS];
    logic [N_PORTS-1:0]       served;

    // Split each port address into its row part.
    always_comb begin
        for (int i = 0; i < N_PORTS; i++)
            rows[i*ROW_W +: ROW_W] = req_addr[i*ADDR_W + BANK_W +: ROW_W];
    end

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        // Decode which ports address this bank.
        always_comb begin
            for (int i = 0; i < N_PORTS; i++)
                hit[b][i] = req_valid[i] &&
                    (int'(req_addr[i*ADDR_W +: BANK_W]) == b);
        end

        xbar_bank_port #(
            .N(N_PORTS), .ROW_W(ROW_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
        ) u_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .hit     (hit[b]),
            .wr      (req_write),
            .row     (rows),
            .wdata   (req_wdata),
            .en      (bank_en[b]),
            .we      (bank_we[b]),
            .addr    (bank_addr[b*ROW_W +: ROW_W]),
            .wdata_o (bank_wdata[b*DATA_W +: DATA_W]),
            .grant   (grant[b])
        );
        assign bank_grant[b*N_PORTS +: N_PORTS] = grant[b];
    end

    // Collect service per port and return read data from its bank.
    always_comb begin
        logic [BANK_W-1:0] bsel;
        served = '0;
        for (int b = 0; b < N_BANKS; b++) served = served | grant[b];
        req_stall = req_valid & ~served;
        for (int i = 0; i < N_PORTS; i++) begin
            bsel = req_addr[i*ADDR_W +: BANK_W];
            req_rdata[i*DATA_W +: DATA_W] = (served[i] && !req_write[i]) ?
                bank_rdata[bsel*DATA_W +: DATA_W] : '0;
        end
    end

    AST_SERVED_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
        (served & ~req_valid) == '0);                           // R10
    AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid == '0) |-> (req_stall == '0 && bank_en == '0)); // R9
endmodule

// File: tb/bcast_xbar_test.sv
`timescale 1ns/1ps
// Directed bench for bcast_xbar: one task per scenario, each checking
// its own results. Banks are modelled here with combinational reads.
module bcast_xbar_test;
    localparam int NP = 4, NB = 4, AW = 10, DW = 16;
    localparam int BW = 2, RW = AW - BW, ROWS = 1 << RW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NP-1:0]    req_valid = '0, req_write = '0;
    logic [NP*AW-1:0] req_addr = '0;
    logic [NP*DW-1:0] req_wdata = '0;
    logic [NP-1:0]    req_stall;
    logic [NP*DW-1:0] req_rdata;
    logic [NB-1:0]    bank_en, bank_we;
    logic [NB*RW-1:0] bank_addr;
    logic [NB*DW-1:0] bank_wdata, bank_rdata;
    logic [NB*NP-1:0] bank_grant;
    logic [DW-1:0]    mem [NB][ROWS];
    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    bcast_xbar uut (.*);

    // Bank models: combinational read, write on the clock edge.
    always_comb
        for (int b = 0; b < NB; b++)
            bank_rdata[b*DW +: DW] = mem[b][bank_addr[b*RW +: RW]];
    always @(posedge clk)
        for (int b = 0; b < NB; b++)
            if (bank_en[b] && bank_we[b])
                mem[b][bank_addr[b*RW +: RW]] <= bank_wdata[b*DW +: DW];

    function automatic logic [DW-1:0] init_val(input int a);
        return DW'(a * 37 + 16'h1200);
    endfunction

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic chk_eq(input string rq, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
        check(act === exp, rq, what, act, exp);
    endtask

    task automatic set_port(input int i, input bit v, input bit w,
                            input int a, input logic [DW-1:0] d);
        req_valid[i] = v;
        req_write[i] = w;
        req_addr[i*AW +: AW] = AW'(a);
        req_wdata[i*DW +: DW] = d;
    endtask

    task automatic idle_all();
        req_valid = '0; req_write = '0; req_addr = '0; req_wdata = '0;
    endtask

    // Advance one edge, then settle before checking.
    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic rd(input int i, output logic [DW-1:0] v);
        v = req_rdata[i*DW +: DW];
    endtask

    task automatic do_reset();
        idle_all();
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
        #1;
    endtask

    task automatic t_idle();
        do_reset();
        chk_eq("R9", "bank_en idle", 32'(bank_en), 0);
        chk_eq("R9", "bank_we idle", 32'(bank_we), 0);
        chk_eq("R10", "stall idle", 32'(req_stall), 0);
        chk_eq("R9", "rdata idle", 32'(req_rdata[31:0]), 0);
    endtask

    // Four reads of one word: one access, all served, same data.
    task automatic t_merge();
        logic [DW-1:0] v;
        int a = (5 << BW) | 0;
        for (int i = 0; i < NP; i++) set_port(i, 1, 0, a, '0);
        #1;
        chk_eq("R3", "stall merged", 32'(req_stall), 0);
        chk_eq("R3", "bank_en merged", 32'(bank_en), 32'b0001);
        chk_eq("R10", "grant bank0", 32'(bank_grant[NP-1:0]), 32'hF);
        chk_eq("R2", "bank_addr0", 32'(bank_addr[RW-1:0]), 5);
        for (int i = 0; i < NP; i++) begin
            rd(i, v);
            chk_eq("R3", $sformatf("rdata port%0d", i), 32'(v), 32'(init_val(a)));
        end
        step(); idle_all();
    endtask

    // Two-row conflict repeated from reset: 0 wins, then 1, then 0.
    task automatic t_rotate();
        logic [DW-1:0] v;
        do_reset();
        set_port(0, 1, 0, (1 << BW) | 1, '0);
        set_port(1, 1, 0, (2 << BW) | 1, '0);
        #1;
        chk_eq("R1", "first winner stalls", 32'(req_stall), 32'b0010);
        rd(0, v);
        chk_eq("R4", "winner data", 32'(v), 32'(init_val((1 << BW) | 1)));
        rd(1, v);
        chk_eq("R9", "loser data zero", 32'(v), 0);
        step();
        chk_eq("R5", "second winner stalls", 32'(req_stall), 32'b0001);
        chk_eq("R10", "grant bank1", 32'(bank_grant[NP +: NP]), 32'b0010);
        step();
        chk_eq("R5", "third winner stalls", 32'(req_stall), 32'b0010);
        step(); idle_all();
    endtask

    // One read per bank, all different rows: everything served.
    task automatic t_spread();
        logic [DW-1:0] v;
        for (int i = 0; i < NP; i++) set_port(i, 1, 0, ((i + 3) << BW) | i, '0);
        #1;
        chk_eq("R8", "no stall spread", 32'(req_stall), 0);
        chk_eq("R8", "all banks on", 32'(bank_en), 32'hF);
        for (int i = 0; i < NP; i++) begin
            rd(i, v);
            chk_eq("R8", $sformatf("spread data%0d", i), 32'(v),
                   32'(init_val(((i + 3) << BW) | i)));
        end
        step(); idle_all();
    endtask

    // A write among same-word reads goes first and alone.
    task automatic t_write_first();
        logic [DW-1:0] v;
        int a = (9 << BW) | 2;
        set_port(0, 1, 0, a, '0);
        set_port(1, 1, 1, a, 16'hBEEF);
        set_port(2, 1, 0, a, '0);
        #1;
        chk_eq("R6", "reads stall behind write", 32'(req_stall), 32'b0101);
        chk_eq("R9", "bank_we on", 32'(bank_we), 32'b0100);
        chk_eq("R6", "bank wdata", 32'(bank_wdata[2*DW +: DW]), 32'hBEEF);
        step();
        set_port(1, 0, 0, 0, '0);
        #1;
        chk_eq("R6", "reads served after", 32'(req_stall), 0);
        rd(0, v); chk_eq("R6", "new word port0", 32'(v), 32'hBEEF);
        rd(2, v); chk_eq("R3", "new word port2", 32'(v), 32'hBEEF);
        step(); idle_all();
    endtask

    // Two writes to one word: one per cycle.
    task automatic t_write_serial();
        int a = (12 << BW) | 3;
        set_port(2, 1, 1, a, 16'h1111);
        set_port(3, 1, 1, a, 16'h2222);
        #1;
        chk_eq("R7", "one writer served", 32'($countones(req_stall)), 1);
        chk_eq("R7", "one grant bit", 32'($countones(bank_grant[3*NP +: NP])), 1);
        step();
        chk_eq("R7", "other writer next", 32'($countones(req_stall)), 1);
        step(); idle_all();
        #1;
        chk_eq("R9", "idle after writes", 32'(bank_en), 0);
    endtask

    initial begin
        for (int b = 0; b < NB; b++)
            for (int r = 0; r < ROWS; r++)
                mem[b][r] = init_val((r << BW) | b);
    end

    initial begin
        t_idle();
        t_merge();
        t_rotate();
        t_spread();
        t_write_first();
        t_write_serial();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule